// File: doc/BRIEF.md
# MMU Special Register Access Gate

This block sits between a processor's special-register read/write path and the state of a memory management unit. It holds the process-identifier register, the zone-protection register and the TLB index register. It also fronts three TLB arrays, one per entry field: a low word, a high word and an 8-bit tag. The processor names a register with a 3-bit select code, issues one request at a time, and receives a single-cycle response with read data and an illegal-access flag.

Every access is filtered by two build-time settings. The first is the MMU mode: values below 2 mean no MMU. The second is a 2-bit TLB access level. Bit 0 of the level grants reads of the protection-sensitive registers, and a level above 1 grants writes to them. A write to the search register starts an external translation lookup and leaves the result in the index register.

The control path is a four-state machine:
- IDLE accepts a request. It goes to RAMRD for a permitted TLB word read, to SEARCH for a permitted search write, and to RESP for everything else.
- RAMRD waits one cycle for the array output and goes to RESP.
- SEARCH holds the lookup request until the lookup completes and then goes to RESP.
- RESP presents the response for one cycle and returns to IDLE.

Select codes: 0 = PID, 1 = ZPR, 2 = INDEX, 3 = TLB low word, 4 = TLB high word, 5 = SEARCH, 6 and 7 unused.

Top module: `mmu_sreg_gate`

## Requirements
- R1: When MMU_MODE is below 2 or ACCESS_LVL is 0, every read returns 0, every write leaves all state unchanged, and neither illegal nor flush_pulse is raised.
- R2: A read of PID (0), ZPR (1), TLB low (3) or TLB high (4) with ACCESS_LVL bit 0 clear returns 0 with illegal high. A read of INDEX (2) is allowed at any nonzero level.
- R3: A write to PID (0), ZPR (1) or SEARCH (5) with ACCESS_LVL at most 1 changes nothing, starts no lookup and raises illegal. Writes to INDEX, TLB low and TLB high need only a nonzero level.
- R4: The TLB entry used by TLB low/high reads and writes is selected by the low IDX_W bits of INDEX (8 bits with the default 256 entries). Higher INDEX bits are kept and read back but do not select the entry.
- R5: A read of the TLB high word returns the stored high word and loads that entry's 8-bit tag into PID.
- R6: A write of the TLB high word also stores the current PID (8 bits) as that entry's tag.
- R7: A permitted SEARCH write raises lookup_req with lookup_page equal to the written value, and holds both until lookup_done. On a hit, INDEX becomes lookup_index zero-extended.
- R8: On a lookup miss, INDEX bit 31 is set and its other bits are kept.
- R9: After reset, PID, ZPR and INDEX read as 0.
- R10: flush_pulse is high for the one response cycle of a PID or ZPR write that changes the stored value. A write of an equal value gives no pulse.
- R11: req_ready is high only in IDLE. rsp_valid lasts exactly one cycle. It comes one cycle after acceptance for register accesses and two cycles after for permitted TLB word reads.
- R12: Select codes 6 and 7 read as 0, ignore writes and raise no illegal flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, taken when req_ready is high |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 3 | Register select code |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_valid |
| illegal | output | 1 | Access refused by the access level, valid with rsp_valid |
| flush_pulse | output | 1 | Translation caches must be invalidated |
| lookup_req | output | 1 | Translation search request |
| lookup_page | output | DATA_W | Page number to search for |
| lookup_done | input | 1 | Search finished |
| lookup_hit | input | 1 | Search found an entry |
| lookup_index | input | IDX_W | Matching entry number |

## Verification
The bench builds four copies side by side, all driven by the same request stream:
- mode 3 with level 3, which can do every operation, including search hits and misses and tag transfer;
- mode 3 with level 1, which can read but is refused privileged writes;
- mode 3 with level 2, which can write but is refused protected reads, and which performs searches alongside the first copy;
- mode 1, which must stay silent and keep all-zero state.

Because the stream is shared, each copy's divergent internal state is brought out through later reads of INDEX, PID and ZPR.

// File: rtl/mmu_sreg_pkg.sv
package mmu_sreg_pkg;

    typedef enum logic [2:0] {
        RS_PID    = 3'd0,
        RS_ZPR    = 3'd1,
        RS_INDEX  = 3'd2,
        RS_LO     = 3'd3,
        RS_HI     = 3'd4,
        RS_SEARCH = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RAMRD,
        ST_SEARCH,
        ST_RESP
    } gate_state_e;

endpackage

// File: rtl/mmu_sreg_decode.sv
module mmu_sreg_decode
    import mmu_sreg_pkg::*;
#(
    parameter int         MMU_MODE   = 3,
    parameter logic [1:0] ACCESS_LVL = 2'd3
) (
    input  logic [2:0] sel,
    input  logic       write,
    output logic       perform,
    output logic       refuse,
    output logic       ram_read,
    output logic       search
);
    localparam bit GATE_OPEN = (MMU_MODE >= 2) && (ACCESS_LVL != 2'd0);
    localparam bit RD_PRIV   = ACCESS_LVL[0];
    localparam bit WR_PRIV   = (ACCESS_LVL > 2'd1);

    logic rd_guarded;
    logic wr_guarded;

    always_comb begin
        rd_guarded = (sel == RS_PID) || (sel == RS_ZPR) || (sel == RS_LO) || (sel == RS_HI);
        wr_guarded = (sel == RS_PID) || (sel == RS_ZPR) || (sel == RS_SEARCH);
        refuse     = GATE_OPEN && ((!write && rd_guarded && !RD_PRIV) ||
                                   (write && wr_guarded && !WR_PRIV));
        perform    = GATE_OPEN && !refuse;
        ram_read   = perform && !write && ((sel == RS_LO) || (sel == RS_HI));
        search     = perform && write && (sel == RS_SEARCH);
    end

endmodule

// File: rtl/mmu_tlb_store.sv
module mmu_tlb_store #(
    parameter int ENTRIES = 256,
    parameter int DATA_W  = 32,
    parameter int TID_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [TID_W-1:0]  tid_in,
    output logic [DATA_W-1:0] lo_q,
    output logic [DATA_W-1:0] hi_q,
    output logic [TID_W-1:0]  tid_q
);
    logic [DATA_W-1:0] mem_lo  [ENTRIES];
    logic [DATA_W-1:0] mem_hi  [ENTRIES];
    logic [TID_W-1:0]  mem_tid [ENTRIES];

    always_ff @(posedge clk) begin
        if (we_lo) mem_lo[idx] <= wdata;
        if (we_hi) begin
            mem_hi[idx]  <= wdata;
            mem_tid[idx] <= tid_in;
        end
        lo_q  <= mem_lo[idx];
        hi_q  <= mem_hi[idx];
        tid_q <= mem_tid[idx];
    end

endmodule

// File: rtl/mmu_sreg_gate.sv
module mmu_sreg_gate
    import mmu_sreg_pkg::*;
#(
    parameter int         MMU_MODE   = 3,
    parameter logic [1:0] ACCESS_LVL = 2'd3,
    parameter int         ENTRIES    = 256,
    parameter int         DATA_W     = 32,
    parameter int         TID_W      = 8,
    localparam int        IDX_W      = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [2:0]        req_sel,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              illegal,
    output logic              flush_pulse,
    output logic              lookup_req,
    output logic [DATA_W-1:0] lookup_page,
    input  logic              lookup_done,
    input  logic              lookup_hit,
    input  logic [IDX_W-1:0]  lookup_index
);
    gate_state_e       state, state_nxt;
    logic              accept;
    logic              dec_perform, dec_refuse, dec_ram_read, dec_search;
    logic [TID_W-1:0]  pid_q;
    logic [DATA_W-1:0] zpr_q, index_q, rdata_q, page_q;
    logic              illegal_q, flush_q, hi_sel_q;
    logic              we_lo, we_hi;
    logic [DATA_W-1:0] lo_q, hi_q;
    logic [TID_W-1:0]  tid_q;

    assign accept = (state == ST_IDLE) && req_valid;

    mmu_sreg_decode #(.MMU_MODE(MMU_MODE), .ACCESS_LVL(ACCESS_LVL)) u_decode (
        .sel      (req_sel),
        .write    (req_write),
        .perform  (dec_perform),
        .refuse   (dec_refuse),
        .ram_read (dec_ram_read),
        .search   (dec_search)
    );

    assign we_lo = accept && dec_perform && req_write && (req_sel == RS_LO);
    assign we_hi = accept && dec_perform && req_write && (req_sel == RS_HI);

    mmu_tlb_store #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .TID_W(TID_W)) u_store (
        .clk    (clk),
        .we_lo  (we_lo),
        .we_hi  (we_hi),
        .idx    (index_q[IDX_W-1:0]),
        .wdata  (req_wdata),
        .tid_in (pid_q),
        .lo_q   (lo_q),
        .hi_q   (hi_q),
        .tid_q  (tid_q)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (dec_ram_read)    state_nxt = ST_RAMRD;
                    else if (dec_search) state_nxt = ST_SEARCH;
                    else                 state_nxt = ST_RESP;
                end
            end
            ST_RAMRD:  state_nxt = ST_RESP;
            ST_SEARCH: if (lookup_done) state_nxt = ST_RESP;
            ST_RESP:   state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready   = (state == ST_IDLE);
        rsp_valid   = (state == ST_RESP);
        lookup_req  = (state == ST_SEARCH);
        lookup_page = page_q;
        rsp_rdata   = rdata_q;
        illegal     = illegal_q;
        flush_pulse = flush_q;
    end

    // Register file and response data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pid_q     <= '0;
            zpr_q     <= '0;
            index_q   <= '0;
            rdata_q   <= '0;
            page_q    <= '0;
            illegal_q <= 1'b0;
            flush_q   <= 1'b0;
            hi_sel_q  <= 1'b0;
        end else begin
            illegal_q <= accept && dec_refuse;
            flush_q   <= accept && dec_perform && req_write &&
                         (((req_sel == RS_PID) && (req_wdata[TID_W-1:0] != pid_q)) ||
                          ((req_sel == RS_ZPR) && (req_wdata != zpr_q)));
            if (accept) begin
                rdata_q  <= '0;
                hi_sel_q <= (req_sel == RS_HI);
                if (dec_perform) begin
                    if (req_write) begin
                        case (req_sel)
                            RS_PID:    pid_q   <= req_wdata[TID_W-1:0];
                            RS_ZPR:    zpr_q   <= req_wdata;
                            RS_INDEX:  index_q <= req_wdata;
                            RS_SEARCH: page_q  <= req_wdata;
                            default:   ;
                        endcase
                    end else begin
                        case (req_sel)
                            RS_PID:   rdata_q <= DATA_W'(pid_q);
                            RS_ZPR:   rdata_q <= zpr_q;
                            RS_INDEX: rdata_q <= index_q;
                            default:  rdata_q <= '0;
                        endcase
                    end
                end
            end
            if (state == ST_RAMRD) begin
                rdata_q <= hi_sel_q ? hi_q : lo_q;
                if (hi_sel_q) pid_q <= tid_q;
            end
            if ((state == ST_SEARCH) && lookup_done) begin
                if (lookup_hit) index_q <= DATA_W'(lookup_index);
                else            index_q[DATA_W-1] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/mmu_sreg_gate_chk.sv
module mmu_sreg_gate_chk #(
    parameter int         MMU_MODE   = 3,
    parameter logic [1:0] ACCESS_LVL = 2'd3,
    parameter int         DATA_W     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              illegal,
    input logic              flush_pulse,
    input logic              lookup_req,
    input logic [DATA_W-1:0] lookup_page,
    input logic              lookup_done
);
    localparam bit CLOSED = (MMU_MODE < 2) || (ACCESS_LVL == 2'd0);

    p_closed_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (CLOSED && rsp_valid) |-> (rsp_rdata == '0 && !illegal && !flush_pulse));

    p_illegal_with_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> rsp_valid);

    p_no_search_unpriv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_req |-> (ACCESS_LVL > 2'd1) && !CLOSED);

    p_page_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_req && !lookup_done) |=> (lookup_req && $stable(lookup_page)));

    p_flush_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |-> ($past(req_valid && req_ready && req_write) && rsp_valid));

    p_rsp_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    p_ready_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !rsp_valid && !lookup_req);

endmodule

bind mmu_sreg_gate mmu_sreg_gate_chk #(
    .MMU_MODE(MMU_MODE), .ACCESS_LVL(ACCESS_LVL), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .illegal(illegal), .flush_pulse(flush_pulse), .lookup_req(lookup_req),
    .lookup_page(lookup_page), .lookup_done(lookup_done)
);

// File: tb/mmu_sreg_gate_tb_top.sv
module mmu_sreg_gate_tb_top;

    typedef struct packed {
        logic        wr;
        logic [2:0]  sel;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic        ill;
        logic        fl;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd2, 32'h0000_0005, 32'h0, 1'b0, 1'b0},  // R4 index 5
        '{1'b1, 3'd0, 32'h0000_002A, 32'h0, 1'b0, 1'b1},  // R10 PID change
        '{1'b1, 3'd4, 32'hAAAA_0005, 32'h0, 1'b0, 1'b0},  // R6 tag 2A
        '{1'b1, 3'd3, 32'h1111_2222, 32'h0, 1'b0, 1'b0},  // R4
        '{1'b1, 3'd0, 32'h0000_0007, 32'h0, 1'b0, 1'b1},  // R10
        '{1'b0, 3'd3, 32'h0, 32'h1111_2222, 1'b0, 1'b0},  // R4
        '{1'b0, 3'd4, 32'h0, 32'hAAAA_0005, 1'b0, 1'b0},  // R5
        '{1'b0, 3'd0, 32'h0, 32'h0000_002A, 1'b0, 1'b0},  // R5 R6 PID from tag
        '{1'b1, 3'd0, 32'h0000_002A, 32'h0, 1'b0, 1'b0},  // R10 same value
        '{1'b1, 3'd1, 32'hC000_0003, 32'h0, 1'b0, 1'b1},  // R10 ZPR change
        '{1'b0, 3'd1, 32'h0, 32'hC000_0003, 1'b0, 1'b0},  // R2
        '{1'b1, 3'd2, 32'h0000_0006, 32'h0, 1'b0, 1'b0},  // R4
        '{1'b1, 3'd3, 32'h0000_3333, 32'h0, 1'b0, 1'b0},  // R4
        '{1'b0, 3'd3, 32'h0, 32'h0000_3333, 1'b0, 1'b0},  // R4
        '{1'b1, 3'd2, 32'h0000_0105, 32'h0, 1'b0, 1'b0},  // R4 upper bits
        '{1'b0, 3'd3, 32'h0, 32'h1111_2222, 1'b0, 1'b0},  // R4 entry 5
        '{1'b0, 3'd6, 32'h0, 32'h0, 1'b0, 1'b0},          // R12
        '{1'b1, 3'd7, 32'hDEAD_BEEF, 32'h0, 1'b0, 1'b0},  // R12
        '{1'b0, 3'd2, 32'h0, 32'h0000_0105, 1'b0, 1'b0},  // R4 kept
        '{1'b1, 3'd1, 32'hC000_0003, 32'h0, 1'b0, 1'b0}   // R10 same ZPR
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_sel = 3'd0;
    logic [31:0] req_wdata = 32'h0;
    logic        lk_done = 1'b0;
    logic        lk_hit = 1'b0;
    logic [7:0]  lk_idx = 8'h0;
    int          lk_cnt = 0;
    logic [31:0] seen_page = 32'h0;

    logic        rdy [4];
    logic        rv  [4];
    logic [31:0] rd  [4];
    logic        il  [4];
    logic        fl  [4];
    logic        lkr [4];
    logic [31:0] lkp [4];

    logic [31:0] got_rd  [4];
    logic        got_il  [4];
    logic        got_fl  [4];
    int          got_lat [4];

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    mmu_sreg_gate #(.MMU_MODE(3), .ACCESS_LVL(2'd3)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[0]),
        .req_write(req_write), .req_sel(req_sel), .req_wdata(req_wdata),
        .rsp_valid(rv[0]), .rsp_rdata(rd[0]), .illegal(il[0]), .flush_pulse(fl[0]),
        .lookup_req(lkr[0]), .lookup_page(lkp[0]), .lookup_done(lk_done),
        .lookup_hit(lk_hit), .lookup_index(lk_idx));

    mmu_sreg_gate #(.MMU_MODE(3), .ACCESS_LVL(2'd1)) dut_l1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[1]),
        .req_write(req_write), .req_sel(req_sel), .req_wdata(req_wdata),
        .rsp_valid(rv[1]), .rsp_rdata(rd[1]), .illegal(il[1]), .flush_pulse(fl[1]),
        .lookup_req(lkr[1]), .lookup_page(lkp[1]), .lookup_done(lk_done),
        .lookup_hit(lk_hit), .lookup_index(lk_idx));

    mmu_sreg_gate #(.MMU_MODE(3), .ACCESS_LVL(2'd2)) dut_l2 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[2]),
        .req_write(req_write), .req_sel(req_sel), .req_wdata(req_wdata),
        .rsp_valid(rv[2]), .rsp_rdata(rd[2]), .illegal(il[2]), .flush_pulse(fl[2]),
        .lookup_req(lkr[2]), .lookup_page(lkp[2]), .lookup_done(lk_done),
        .lookup_hit(lk_hit), .lookup_index(lk_idx));

    mmu_sreg_gate #(.MMU_MODE(1), .ACCESS_LVL(2'd3)) dut_off (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[3]),
        .req_write(req_write), .req_sel(req_sel), .req_wdata(req_wdata),
        .rsp_valid(rv[3]), .rsp_rdata(rd[3]), .illegal(il[3]), .flush_pulse(fl[3]),
        .lookup_req(lkr[3]), .lookup_page(lkp[3]), .lookup_done(lk_done),
        .lookup_hit(lk_hit), .lookup_index(lk_idx));

    // Lookup responder: answers the full-access copy after three cycles
    always @(negedge clk) begin
        lk_done <= 1'b0;
        if (lkr[0] && !lk_done) begin
            if (lk_cnt == 2) begin
                lk_done   <= 1'b1;
                lk_cnt    <= 0;
                seen_page <= lkp[0];
            end else begin
                lk_cnt <= lk_cnt + 1;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [2:0] s, input logic [31:0] d);
        for (int j = 0; j < 4; j++) begin
            got_rd[j] = 32'hFFFF_FFFF; got_il[j] = 1'bx; got_fl[j] = 1'bx; got_lat[j] = 0;
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_sel = s; req_wdata = d;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (k == 1) req_valid = 1'b0;
            for (int j = 0; j < 4; j++) begin
                if (rv[j]) begin
                    got_rd[j] = rd[j]; got_il[j] = il[j]; got_fl[j] = fl[j]; got_lat[j] = k;
                end
            end
        end
    endtask

    initial begin
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        access(1'b0, 3'd0, 0); check("R9 pid", got_rd[0], 32'h0);
        access(1'b0, 3'd1, 0); check("R9 zpr", got_rd[0], 32'h0);
        access(1'b0, 3'd2, 0); check("R9 index", got_rd[0], 32'h0);
        check("R11 register latency", got_lat[0], 1);
        check("R11 ready after rsp", {31'h0, rdy[0]}, 32'h1);

        // Vector table on the full-access copy
        for (int v = 0; v < NV; v++) begin
            access(VEC[v].wr, VEC[v].sel, VEC[v].wdata);
            check($sformatf("vec%0d R4/R5/R6/R10/R12 data", v), got_rd[0], VEC[v].exp);
            check($sformatf("vec%0d R2/R3 illegal", v), {31'h0, got_il[0]}, {31'h0, VEC[v].ill});
            check($sformatf("vec%0d R10 flush", v), {31'h0, got_fl[0]}, {31'h0, VEC[v].fl});
        end

        // R1 closed copy kept nothing
        access(1'b0, 3'd2, 0);
        check("R1 closed index", got_rd[3], 32'h0);
        check("R1 closed no illegal", {31'h0, got_il[3]}, 32'h0);
        check("R2 index readable at level2", got_rd[2], 32'h0000_0105);
        check("R1 open index", got_rd[0], 32'h0000_0105);

        // R2 PID read refused at level 2, allowed at level 1
        access(1'b0, 3'd0, 0);
        check("R2 l2 pid data", got_rd[2], 32'h0);
        check("R2 l2 pid illegal", {31'h0, got_il[2]}, 32'h1);
        check("R2 l1 pid illegal", {31'h0, got_il[1]}, 32'h0);
        check("R3 l1 pid never written", got_rd[1], 32'h0);
        check("R5 full pid", got_rd[0], 32'h0000_002A);

        // R2 TLB high read, R11 RAM latency
        access(1'b0, 3'd4, 0);
        check("R2 l2 hi illegal", {31'h0, got_il[2]}, 32'h1);
        check("R2 l2 hi refused latency", got_lat[2], 1);
        check("R5 full hi", got_rd[0], 32'hAAAA_0005);
        check("R11 ram latency", got_lat[0], 2);
        check("R5 l1 hi", got_rd[1], 32'hAAAA_0005);

        // R3 ZPR write refused at level 1
        access(1'b1, 3'd1, 32'h0000_0055);
        check("R3 l1 zpr illegal", {31'h0, got_il[1]}, 32'h1);
        check("R3 l1 no flush", {31'h0, got_fl[1]}, 32'h0);
        check("R10 full zpr flush", {31'h0, got_fl[0]}, 32'h1);
        check("R1 closed write no illegal", {31'h0, got_il[3]}, 32'h0);
        access(1'b0, 3'd1, 0);
        check("R3 l1 zpr unchanged", got_rd[1], 32'h0);
        check("R3 full zpr", got_rd[0], 32'h0000_0055);

        // R7 search hit
        lk_hit = 1'b1; lk_idx = 8'h33;
        access(1'b1, 3'd5, 32'hABCD_E000);
        check("R3 l1 search illegal", {31'h0, got_il[1]}, 32'h1);
        check("R7 search legal", {31'h0, got_il[0]}, 32'h0);
        check("R7 page", seen_page, 32'hABCD_E000);
        access(1'b0, 3'd2, 0);
        check("R7 hit index", got_rd[0], 32'h0000_0033);
        check("R7 l2 hit index", got_rd[2], 32'h0000_0033);
        check("R3 l1 index untouched", got_rd[1], 32'h0000_0105);

        // R8 search miss
        lk_hit = 1'b0;
        access(1'b1, 3'd5, 32'h0000_1000);
        access(1'b0, 3'd2, 0);
        check("R8 miss index", got_rd[0], 32'h8000_0033);

        // R6 tag capture on a fresh entry
        access(1'b1, 3'd2, 32'h0000_0009);
        access(1'b1, 3'd0, 32'h0000_005C);
        access(1'b1, 3'd4, 32'h1234_0009);
        access(1'b1, 3'd0, 32'h0000_0001);
        access(1'b0, 3'd4, 0);
        check("R5 hi entry 9", got_rd[0], 32'h1234_0009);
        access(1'b0, 3'd0, 0);
        check("R6 tag restored to pid", got_rd[0], 32'h0000_005C);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule